// File: doc/BRIEF.md
# Programmable Clock Channel Divider

This block is one output channel of a clock distribution tree. It divides its input clock into a waveform whose high and low phases are programmed separately, each as a count of input-clock cycles. A chip-level SYNC input holds the channel at a programmed start level. When SYNC is released, the channel waits a programmed number of offset cycles before it runs. Channels with equal settings therefore leave SYNC with aligned edges.

A small register-style write port sets the phase lengths, the start level, the offset and the mode bits. Bypass hands the raw input clock to the output. A force mode parks the output at a static level, but only on a channel that ignores SYNC. A direct-routing mode, steered by a 2-bit source select input, replaces the channel output with one of two undivided sources. Phase-length changes take effect only at a phase boundary or at a restart, so a write never cuts a phase short.

Top module: `clk_chan_div`

## Requirements
- R1: While `rst` is high on a rising edge, `clk_out` is low and every configuration field clears to zero. After reset is released, the channel runs with one-cycle low and one-cycle high phases, starting low.
- R2: Register 0 holds the high-phase count minus one in bits [3:0] and the low-phase count minus one in bits [7:4]. While running, each high phase lasts high+1 input cycles and each low phase lasts low+1 input cycles.
- R3: When register 1 bit 2 (bypass) is set and direct routing is not active, `clk_out` follows `clk`. The counter stays idle, and after bypass clears the channel restarts exactly as it does after a SYNC release.
- R4: When register 1 bit 1 (sync-ignore) is set, `sync_i` has no effect on the divided waveform.
- R5: When register 1 bit 1 is clear, `clk_out` holds the start level from register 1 bit 0 (1 = high) from the rising edge after `sync_i` is sampled high, for as long as `sync_i` stays high.
- R6: Register 2 bits [3:0] hold an offset. The first change of `clk_out` away from the start level comes offset+m+1 input cycles after the last rising edge at which `sync_i` was sampled high, where m is the minus-one count of the start phase.
- R7: Register 1 bit 3 enables force and bit 4 gives the forced level. Force drives `clk_out` to that level only when sync-ignore is also set. When sync-ignore is clear, force has no effect on the output.
- R8: When register 1 bit 5 (direct) is set, `direct_sel` = 2'b10 routes `src_osc` to `clk_out` and 2'b00 routes `src_ext`. Codes 2'b01 and 2'b11 leave the channel path in use. A valid direct route overrides both bypass and force.
- R9: A change to either phase count that is written during a phase leaves that phase's length as it was. The new counts apply from the next phase boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Chip-level SYNC, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| direct_sel | input | 2 | Undivided source select for direct routing |
| src_osc | input | 1 | Undivided oscillator-path source |
| src_ext | input | 1 | Undivided external-clock source |
| clk_out | output | 1 | Channel clock output |

## Verification
The hardest situation to reach from the ports is a phase-count write that lands in the middle of a running phase. The bench first aligns the channel with a SYNC pulse. It then counts whole phases sample by sample, so it knows which cycle of the high phase it is in when the write issues, and it checks the old length, then the new one. Offset timing is reached the same way: the sample count starts at the SYNC release, so the offset and the start phase are measured together as one run.

// File: rtl/clk_chan_div_pkg.sv
package clk_chan_div_pkg;

    localparam int CNT_W  = 4;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_LEN = 2'd0;
    localparam logic [ADDR_W-1:0] REG_CTL = 2'd1;
    localparam logic [ADDR_W-1:0] REG_OFF = 2'd2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WAIT = 1'b1
    } phase_st_t;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'b00,
        SRC_DIV  = 2'b01,
        SRC_OSC  = 2'b10,
        SRC_DIV2 = 2'b11
    } src_sel_t;

    typedef struct packed {
        cnt_t hi_m1;
        cnt_t lo_m1;
        cnt_t off;
        logic start_high;
        logic nosync;
        logic bypass;
        logic force_en;
        logic force_lvl;
        logic direct_en;
    } chan_cfg_t;

    function automatic chan_cfg_t apply_ctl(chan_cfg_t c, logic [DATA_W-1:0] d);
        chan_cfg_t r;
        r            = c;
        r.start_high = d[0];
        r.nosync     = d[1];
        r.bypass     = d[2];
        r.force_en   = d[3];
        r.force_lvl  = d[4];
        r.direct_en  = d[5];
        return r;
    endfunction

    function automatic logic direct_valid(logic en, logic [1:0] sel);
        return en && (sel == SRC_OSC || sel == SRC_EXT);
    endfunction

endpackage

// File: rtl/clk_chan_cfg.sv
module clk_chan_cfg
    import clk_chan_div_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output chan_cfg_t     cfg_o
);
    chan_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            case (addr)
                REG_LEN: begin
                    cfg_q.hi_m1 <= wdata[CW-1:0];
                    cfg_q.lo_m1 <= wdata[2*CW-1:CW];
                end
                REG_CTL: cfg_q <= apply_ctl(cfg_q, wdata);
                REG_OFF: cfg_q.off <= wdata[CW-1:0];
                default: cfg_q <= cfg_q;
            endcase
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/clk_chan_phase.sv
module clk_chan_phase
    import clk_chan_div_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart_i,
    input  chan_cfg_t cfg_i,
    output logic      div_o,
    output phase_st_t st_o
);
    logic      out_q;
    phase_st_t st_q;
    cnt_t      cnt_q;
    cnt_t      act_hi, act_lo, act_off;
    cnt_t      cur_len;
    logic      wait_done;

    assign cur_len   = out_q ? act_hi : act_lo;
    assign wait_done = ({1'b0, cnt_q} + {{CW{1'b0}}, 1'b1}) == {1'b0, act_off};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= 1'b0;
            st_q    <= ST_RUN;
            cnt_q   <= '0;
            act_hi  <= '0;
            act_lo  <= '0;
            act_off <= '0;
        end else if (restart_i) begin
            out_q   <= cfg_i.start_high;
            cnt_q   <= '0;
            act_hi  <= cfg_i.hi_m1;
            act_lo  <= cfg_i.lo_m1;
            act_off <= cfg_i.off;
            st_q    <= (cfg_i.off == '0) ? ST_RUN : ST_WAIT;
        end else if (st_q == ST_WAIT) begin
            if (wait_done) begin
                st_q  <= ST_RUN;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == cur_len) begin
                out_q  <= ~out_q;
                cnt_q  <= '0;
                act_hi <= cfg_i.hi_m1;
                act_lo <= cfg_i.lo_m1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign div_o = out_q;
    assign st_o  = st_q;

    // R2: the phase counter never runs past the active phase length
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN) |-> (cnt_q <= cur_len));

    // R9: no output edge is produced before the active phase is complete
    assert_no_runt_R9: assert property (@(posedge clk) disable iff (rst)
        (!restart_i && st_q == ST_RUN && cnt_q != cur_len) |=> $stable(out_q));

    // R6: the output stays at the start level through the offset wait
    assert_offset_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && !restart_i) |=> $stable(out_q));
endmodule

// File: rtl/clk_chan_outsel.sv
module clk_chan_outsel
    import clk_chan_div_pkg::*;
(
    input  logic       clk_i,
    input  logic       div_i,
    input  chan_cfg_t  cfg_i,
    input  logic [1:0] sel_i,
    input  logic       src_osc_i,
    input  logic       src_ext_i,
    output logic       out_o
);
    logic direct_hit;

    assign direct_hit = direct_valid(cfg_i.direct_en, sel_i);

    always_comb begin
        if (direct_hit) begin
            out_o = (sel_i == SRC_OSC) ? src_osc_i : src_ext_i;
        end else if (cfg_i.bypass) begin
            out_o = clk_i;
        end else if (cfg_i.nosync && cfg_i.force_en) begin
            out_o = cfg_i.force_lvl;
        end else begin
            out_o = div_i;
        end
    end
endmodule

// File: rtl/clk_chan_div.sv
module clk_chan_div
    import clk_chan_div_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_i,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic [1:0]    direct_sel,
    input  logic          src_osc,
    input  logic          src_ext,
    output logic          clk_out
);
    chan_cfg_t cfg_w;
    logic      restart_w;
    logic      div_w;
    phase_st_t st_w;

    clk_chan_cfg #(.AW(AW), .DW(DW), .CW(CW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg_o (cfg_w)
    );

    assign restart_w = (sync_i && !cfg_w.nosync) || cfg_w.bypass;

    clk_chan_phase #(.CW(CW)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart_w),
        .cfg_i     (cfg_w),
        .div_o     (div_w),
        .st_o      (st_w)
    );

    clk_chan_outsel u_outsel (
        .clk_i     (clk),
        .div_i     (div_w),
        .cfg_i     (cfg_w),
        .sel_i     (direct_sel),
        .src_osc_i (src_osc),
        .src_ext_i (src_ext),
        .out_o     (clk_out)
    );

    // R5: a SYNC the channel obeys puts the start level on the divider
    assert_sync_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (sync_i && !cfg_w.nosync && !cfg_w.bypass) |=> (div_w == $past(cfg_w.start_high)));

    // R3: the counter stays idle for as long as bypass is held
    assert_bypass_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_w.bypass && $past(cfg_w.bypass) && $stable(cfg_w.start_high)) |=> $stable(div_w));

    // R7: force with sync-ignore parks the output at the forced level
    assert_force_level_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_w.nosync && cfg_w.force_en && !cfg_w.bypass && !cfg_w.direct_en)
            |-> (clk_out == cfg_w.force_lvl));

    // R1: the output is low on the cycle after a reset edge
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !clk_out || cfg_w.bypass);
endmodule

// File: tb/clk_chan_div_test.sv
module clk_chan_div_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_i = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] direct_sel = 2'b01;
    logic       src_osc = 1'b0;
    logic       src_ext = 1'b0;
    logic       clk_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    clk_chan_div uut (
        .clk        (clk),
        .rst        (rst),
        .sync_i     (sync_i),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .direct_sel (direct_sel),
        .src_osc    (src_osc),
        .src_ext    (src_ext),
        .clk_out    (clk_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // every task is entered and left at a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input logic st, input logic ns, input logic bp,
                                       input logic fe, input logic fl, input logic de);
        return {2'b00, de, fl, fe, bp, ns, st};
    endfunction

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (clk_out == lvl && n < 64) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic sync_release();
        sync_i = 1'b1;
        repeat (2) @(negedge clk);
        sync_i = 1'b0;
    endtask

    task automatic expect_const(input string tag, input logic lvl, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (clk_out != lvl) bad++;
            @(negedge clk);
        end
        check(tag, bad, 0);
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(negedge clk);
        check("R1 out low in reset", clk_out, 0);
        rst = 1'b0;
        run_len(1'b0, n); check("R1 first low phase", n, 1);
        run_len(1'b1, n); check("R1 first high phase", n, 1);
    endtask

    task automatic t_lengths();
        int n;
        wr(2'd0, 8'h42);            // low m1=4, high m1=2
        wr(2'd2, 8'h00);
        wr(2'd1, ctl(0,0,0,0,0,0));
        sync_release();
        run_len(1'b0, n); check("R6 start low offset 0", n, 5);
        run_len(1'b1, n); check("R2 high phase", n, 3);
        run_len(1'b0, n); check("R2 low phase", n, 5);
        run_len(1'b1, n); check("R2 high phase again", n, 3);
    endtask

    task automatic t_offset();
        int n;
        wr(2'd0, 8'h21);            // low m1=2, high m1=1
        wr(2'd2, 8'h03);
        wr(2'd1, ctl(1,0,0,0,0,0));
        sync_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 held at start level", clk_out, 1);
        sync_i = 1'b0;
        run_len(1'b1, n); check("R6 offset plus start phase", n, 5);
        run_len(1'b0, n); check("R2 low after offset", n, 3);
        run_len(1'b1, n); check("R2 high after offset", n, 2);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_nosync();
        int n;
        wr(2'd0, 8'h11);
        wr(2'd1, ctl(0,1,0,0,0,0));
        sync_i = 1'b1;
        run_len(clk_out, n);
        run_len(clk_out, n); check("R4 sync ignored phase a", n, 2);
        run_len(clk_out, n); check("R4 sync ignored phase b", n, 2);
        sync_i = 1'b0;
    endtask

    task automatic t_force();
        int n;
        wr(2'd1, ctl(0,1,0,1,1,0));
        expect_const("R7 forced high", 1'b1, 8);
        wr(2'd1, ctl(0,1,0,1,0,0));
        expect_const("R7 forced low", 1'b0, 8);
        wr(2'd1, ctl(0,0,0,1,1,0));
        sync_release();
        run_len(1'b0, n); check("R7 force ignored low", n, 2);
        run_len(1'b1, n); check("R7 force ignored high", n, 2);
    endtask

    task automatic t_bypass();
        int n;
        wr(2'd0, 8'h21);
        wr(2'd1, ctl(0,0,1,0,0,0));
        @(posedge clk); #(CLK_P/4);
        check("R3 bypass follows clk high", clk_out, 1);
        @(negedge clk); #(CLK_P/4);
        check("R3 bypass follows clk low", clk_out, 0);
        @(negedge clk);
        wr(2'd1, ctl(0,0,0,0,0,0));
        run_len(1'b0, n); check("R3 restart after bypass", n, 3);
        run_len(1'b1, n); check("R3 high after bypass", n, 2);
    endtask

    task automatic t_direct();
        wr(2'd1, ctl(0,1,0,1,1,1));
        direct_sel = 2'b10; src_osc = 1'b0; src_ext = 1'b1; #1;
        check("R8 osc route low", clk_out, 0);
        src_osc = 1'b1; #1;
        check("R8 osc route high", clk_out, 1);
        direct_sel = 2'b00; #1;
        check("R8 ext route high", clk_out, 1);
        src_ext = 1'b0; #1;
        check("R8 ext route low", clk_out, 0);
        direct_sel = 2'b01; #1;
        check("R8 code 01 keeps channel", clk_out, 1);
        direct_sel = 2'b11; #1;
        check("R8 code 11 keeps channel", clk_out, 1);
        @(negedge clk);
        wr(2'd1, ctl(0,0,1,0,0,1));
        direct_sel = 2'b00; src_ext = 1'b1; #1;
        check("R8 direct beats bypass", clk_out, 1);
        direct_sel = 2'b01; src_ext = 1'b0;
        @(negedge clk);
        wr(2'd1, ctl(0,0,0,0,0,0));
    endtask

    task automatic t_boundary();
        int n;
        wr(2'd0, 8'h22);
        sync_release();
        run_len(1'b0, n); check("R9 setup low", n, 3);
        wr(2'd0, 8'h25);            // high m1 becomes 5 mid-phase
        run_len(1'b1, n); check("R9 current high keeps old length", n, 2);
        run_len(1'b0, n); check("R9 low unchanged", n, 3);
        run_len(1'b1, n); check("R9 next high uses new length", n, 6);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_lengths();
        t_offset();
        t_nosync();
        t_force();
        t_bypass();
        t_direct();
        t_boundary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule